// File: doc/BRIEF.md
# Ad-hoc Conversion Request Register Block

This block holds the software-facing registers for one-off converter requests. These requests are made outside the regular scan schedule. Software writes a configuration word that selects a channel, a reference option and a sample period. That write is the request: the block latches the fields, raises an active status bit and asks the sequencer for a slot by holding `seq_req` high.

The sequencer answers over a small handshake:
- `seq_ack` takes the pending request into conversion.
- `seq_abort` returns it to pending when a scheduled conversion preempts it, so it is retried without software help.
- `seq_done` finishes it and delivers the sample.

On finish, the sample is kept in a result register of its own, apart from the scheduled-result path. A done flag is set, and it raises the interrupt line only while software has enabled it. Requests are not queued. A configuration write that arrives while a request is active is discarded whole.

Top module: `adhoc_regs`

## Requirements
- R1: After reset, active, `seq_req`, `irq`, the done flag, the enable bit, the result and the configuration fields are all zero.
- R2: A write to address 0 while not active latches channel from bits [4:0], reference from bits [9:8] and sample period from bits [23:16]. From the next cycle, active is 1 and `seq_req` is 1.
- R3: A write to address 0 while active is ignored. The configuration outputs and the address-0 readback keep their old values, and no new request is made.
- R4: An `seq_ack` pulse while `seq_req` is high lowers `seq_req` from the next cycle, and active stays 1.
- R5: An `seq_abort` pulse during conversion (active high, `seq_req` low) raises `seq_req` again from the next cycle. Active stays 1 and the configuration is unchanged.
- R6: An `seq_done` pulse during conversion clears active from the next cycle, stores `seq_result` in the result register (address 3, bits [11:0]) and sets the done flag.
- R7: `seq_done` and `seq_abort` have no effect unless a conversion is running. When the request is only pending, active and `seq_req` stay 1.
- R8: `irq` is 1 exactly when the done flag is set and the enable bit (address 2, bit 0) is 1.
- R9: Writing 1 to address 1 bit 1 clears the done flag. If a completion arrives in the same cycle, the flag stays set.
- R10: Reads are registered. `rd_data` is valid in the cycle after `rd_en`. Address 1 returns active in bit 0 and done in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Bus write address |
| wr_data | input | 32 | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 2 | Bus read address |
| rd_data | output | 32 | Registered read data |
| seq_req | output | 1 | Request pending toward the sequencer |
| seq_ack | input | 1 | Sequencer takes the request |
| seq_abort | input | 1 | Sequencer preempted the conversion |
| seq_done | input | 1 | Sequencer finished the conversion |
| seq_result | input | 12 | Conversion sample |
| cfg_chan | output | 5 | Latched channel number |
| cfg_ref | output | 2 | Latched reference option |
| cfg_samp | output | 8 | Latched sample period |
| irq | output | 1 | Done interrupt |

## Verification
A wrong request state shows at the ports on the cycle after the handshake pulse that caused it. `seq_req` fails to drop or reappear, or active reads back wrong one read later. A configuration latch that accepts a write while active shows at once on `cfg_chan`, `cfg_ref` and `cfg_samp`. A done flag that loses the race with a clear shows as a missing `irq` and a zero in status bit 1 on the next read.

// File: rtl/adhoc_pkg.sv
package adhoc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } adhoc_state_e;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_RES  = 2'd3;

  localparam int REF_LSB  = 8;
  localparam int SP_LSB   = 16;
  localparam int ACT_BIT  = 0;
  localparam int DONE_BIT = 1;
endpackage

// File: rtl/adhoc_ctrl.sv
module adhoc_ctrl
  import adhoc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_wr,
  input  logic seq_ack,
  input  logic seq_abort,
  input  logic seq_done,
  output logic accept_o,
  output logic finish_o,
  output logic active_o,
  output logic seq_req_o
);
  adhoc_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_wr) begin
        state_d  = ST_PEND;
        accept_o = 1'b1;
      end
      ST_PEND: if (seq_ack) state_d = ST_RUN;
      ST_RUN: begin
        if (seq_done) begin
          state_d  = ST_IDLE;
          finish_o = 1'b1;
        end else if (seq_abort) begin
          state_d = ST_PEND;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign active_o  = (state_q != ST_IDLE);
  assign seq_req_o = (state_q == ST_PEND);
endmodule

// File: rtl/adhoc_cfg_reg.sv
module adhoc_cfg_reg
  import adhoc_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int REF_W = 2,
  parameter int SP_W  = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DW-1:0]    wdata,
  output logic [CH_W-1:0]  chan_o,
  output logic [REF_W-1:0] ref_o,
  output logic [SP_W-1:0]  samp_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_o <= '0;
      ref_o  <= '0;
      samp_o <= '0;
    end else if (load) begin
      chan_o <= wdata[CH_W-1:0];
      ref_o  <= wdata[REF_LSB +: REF_W];
      samp_o <= wdata[SP_LSB +: SP_W];
    end
  end
endmodule

// File: rtl/adhoc_flag.sv
module adhoc_flag #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic [RES_W-1:0] result_in,
  input  logic             clr,
  input  logic             mask_wr,
  input  logic             mask_in,
  output logic             done_o,
  output logic             mask_o,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);
  logic done_d, mask_d;

  always_comb begin
    done_d = set ? 1'b1 : (clr ? 1'b0 : done_o);
    mask_d = mask_wr ? mask_in : mask_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      mask_o   <= 1'b0;
      irq_o    <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= done_d;
      mask_o <= mask_d;
      irq_o  <= done_d & mask_d;
      if (set) result_o <= result_in;
    end
  end
endmodule

// File: rtl/adhoc_regs.sv
module adhoc_regs
  import adhoc_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int REF_W = 2,
  parameter int SP_W  = 8,
  parameter int RES_W = 12,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             seq_req,
  input  logic             seq_ack,
  input  logic             seq_abort,
  input  logic             seq_done,
  input  logic [RES_W-1:0] seq_result,
  output logic [CH_W-1:0]  cfg_chan,
  output logic [REF_W-1:0] cfg_ref,
  output logic [SP_W-1:0]  cfg_samp,
  output logic             irq
);
  logic cfg_wr, stat_wr, mask_wr;
  logic accept_w, finish_w, active_w;
  logic done_w, mask_w;
  logic [RES_W-1:0] result_w;
  logic [DW-1:0] rd_mux;
  logic unused_wdata;

  assign cfg_wr  = wr_en && (wr_addr == A_CFG);
  assign stat_wr = wr_en && (wr_addr == A_STAT);
  assign mask_wr = wr_en && (wr_addr == A_MASK);
  assign unused_wdata = ^wr_data;

  adhoc_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .req_wr    (cfg_wr),
    .seq_ack   (seq_ack),
    .seq_abort (seq_abort),
    .seq_done  (seq_done),
    .accept_o  (accept_w),
    .finish_o  (finish_w),
    .active_o  (active_w),
    .seq_req_o (seq_req)
  );

  adhoc_cfg_reg #(.CH_W(CH_W), .REF_W(REF_W), .SP_W(SP_W), .DW(DW)) cfg_i (
    .clk    (clk),
    .rst    (rst),
    .load   (accept_w),
    .wdata  (wr_data),
    .chan_o (cfg_chan),
    .ref_o  (cfg_ref),
    .samp_o (cfg_samp)
  );

  adhoc_flag #(.RES_W(RES_W)) flag_i (
    .clk       (clk),
    .rst       (rst),
    .set       (finish_w),
    .result_in (seq_result),
    .clr       (stat_wr && wr_data[DONE_BIT]),
    .mask_wr   (mask_wr),
    .mask_in   (wr_data[0]),
    .done_o    (done_w),
    .mask_o    (mask_w),
    .result_o  (result_w),
    .irq_o     (irq)
  );

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      A_CFG: begin
        rd_mux[CH_W-1:0]         = cfg_chan;
        rd_mux[REF_LSB +: REF_W] = cfg_ref;
        rd_mux[SP_LSB +: SP_W]   = cfg_samp;
      end
      A_STAT: begin
        rd_mux[ACT_BIT]  = active_w;
        rd_mux[DONE_BIT] = done_w;
      end
      A_MASK:  rd_mux[0] = mask_w;
      default: rd_mux[RES_W-1:0] = result_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/adhoc_regs_chk.sv
module adhoc_regs_chk #(
  parameter int CH_W  = 5,
  parameter int REF_W = 2,
  parameter int SP_W  = 8,
  parameter int AW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic             seq_ack,
  input logic             seq_abort,
  input logic             seq_done,
  input logic             seq_req,
  input logic             active,
  input logic             done_flag,
  input logic             irq,
  input logic [CH_W-1:0]  cfg_chan,
  input logic [REF_W-1:0] cfg_ref,
  input logic [SP_W-1:0]  cfg_samp
);
  a_r2_req_starts: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0 && !active) |=> (active && seq_req));

  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    active |=> ($stable(cfg_chan) && $stable(cfg_ref) && $stable(cfg_samp)));

  a_r4_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
    (seq_req && seq_ack) |=> (!seq_req && active));

  a_r5_abort_retries: assert property (@(posedge clk) disable iff (rst)
    (active && !seq_req && seq_abort && !seq_done) |=> (seq_req && active));

  a_r6_done_finishes: assert property (@(posedge clk) disable iff (rst)
    (active && !seq_req && seq_done) |=> (!active && done_flag));

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_flag);

  a_r2_req_implies_active: assert property (@(posedge clk) disable iff (rst)
    seq_req |-> active);
endmodule

bind adhoc_regs adhoc_regs_chk #(.CH_W(CH_W), .REF_W(REF_W), .SP_W(SP_W), .AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .seq_ack   (seq_ack),
  .seq_abort (seq_abort),
  .seq_done  (seq_done),
  .seq_req   (seq_req),
  .active    (active_w),
  .done_flag (done_w),
  .irq       (irq),
  .cfg_chan  (cfg_chan),
  .cfg_ref   (cfg_ref),
  .cfg_samp  (cfg_samp)
);

// File: tb/adhoc_regs_tb_top.sv
module adhoc_regs_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic seq_req, seq_ack = 1'b0, seq_abort = 1'b0, seq_done = 1'b0;
  logic [11:0] seq_result = '0;
  logic [4:0] cfg_chan;
  logic [1:0] cfg_ref;
  logic [7:0] cfg_samp;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  adhoc_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .seq_req(seq_req),
    .seq_ack(seq_ack), .seq_abort(seq_abort), .seq_done(seq_done),
    .seq_result(seq_result), .cfg_chan(cfg_chan), .cfg_ref(cfg_ref),
    .cfg_samp(cfg_samp), .irq(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_ack();
    seq_ack = 1'b1; @(negedge clk); seq_ack = 1'b0;
  endtask
  task automatic pulse_abort();
    seq_abort = 1'b1; @(negedge clk); seq_abort = 1'b0;
  endtask
  task automatic pulse_done(input logic [11:0] r);
    seq_result = r; seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;
  endtask

  task automatic t_reset();
    chk(!seq_req && !irq, "R1 req/irq", {30'd0, seq_req, irq}, 0);
    chk(cfg_chan == 0 && cfg_ref == 0 && cfg_samp == 0, "R1 cfg", {cfg_samp, cfg_ref, cfg_chan}, 0);
    bus_rd(2'd1, rv); chk(rv == 0, "R1 status", rv, 0);
    bus_rd(2'd3, rv); chk(rv == 0, "R1 result", rv, 0);
  endtask

  task automatic t_request();
    bus_wr(2'd0, 32'h0040_0205);
    chk(seq_req, "R2 seq_req", {31'd0, seq_req}, 1);
    chk(cfg_chan == 5 && cfg_ref == 2 && cfg_samp == 8'h40, "R2 cfg", {cfg_samp, cfg_ref, cfg_chan}, {8'h40, 2'd2, 5'd5});
    bus_rd(2'd1, rv); chk(rv == 32'h1, "R10 status active", rv, 32'h1);
    bus_rd(2'd0, rv); chk(rv == 32'h0040_0205, "R10 cfg readback", rv, 32'h0040_0205);
  endtask

  task automatic t_ignored();
    bus_wr(2'd0, 32'h0011_0113);
    chk(cfg_chan == 5 && cfg_ref == 2 && cfg_samp == 8'h40, "R3 cfg kept", {cfg_samp, cfg_ref, cfg_chan}, {8'h40, 2'd2, 5'd5});
    bus_rd(2'd0, rv); chk(rv == 32'h0040_0205, "R3 readback kept", rv, 32'h0040_0205);
  endtask

  task automatic t_stray_pending();
    pulse_done(12'h111);
    chk(seq_req, "R7 done while pending", {31'd0, seq_req}, 1);
    bus_rd(2'd1, rv); chk(rv == 32'h1, "R7 status unchanged", rv, 32'h1);
  endtask

  task automatic t_ack_abort();
    pulse_ack();
    chk(!seq_req, "R4 req drops", {31'd0, seq_req}, 0);
    bus_rd(2'd1, rv); chk(rv == 32'h1, "R4 still active", rv, 32'h1);
    pulse_abort();
    chk(seq_req, "R5 retry req", {31'd0, seq_req}, 1);
    chk(cfg_chan == 5 && cfg_samp == 8'h40, "R5 cfg kept", {cfg_samp, cfg_ref, cfg_chan}, {8'h40, 2'd2, 5'd5});
    bus_rd(2'd1, rv); chk(rv == 32'h1, "R5 active kept", rv, 32'h1);
    pulse_ack();
  endtask

  task automatic t_done();
    pulse_done(12'hABC);
    chk(!seq_req && !irq, "R6 req low, R8 irq masked", {30'd0, seq_req, irq}, 0);
    bus_rd(2'd1, rv); chk(rv == 32'h2, "R6 status done", rv, 32'h2);
    bus_rd(2'd3, rv); chk(rv == 32'hABC, "R6 result", rv, 32'hABC);
  endtask

  task automatic t_irq();
    bus_wr(2'd2, 32'h1);
    chk(irq, "R8 irq on unmask", {31'd0, irq}, 1);
    bus_wr(2'd1, 32'h2);
    chk(!irq, "R9 irq after clear", {31'd0, irq}, 0);
    bus_rd(2'd1, rv); chk(rv == 32'h0, "R9 flag cleared", rv, 0);
  endtask

  task automatic t_race();
    bus_wr(2'd0, 32'h00FF_031F);
    chk(cfg_chan == 5'h1F && cfg_ref == 3 && cfg_samp == 8'hFF, "R2 second request", {cfg_samp, cfg_ref, cfg_chan}, {8'hFF, 2'd3, 5'h1F});
    pulse_ack();
    seq_result = 12'h5A5; seq_done = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h2;
    @(negedge clk);
    seq_done = 1'b0; wr_en = 1'b0;
    chk(irq, "R9 set wins irq", {31'd0, irq}, 1);
    bus_rd(2'd1, rv); chk(rv == 32'h2, "R9 set wins flag", rv, 32'h2);
    pulse_abort();
    chk(!seq_req, "R7 abort while idle", {31'd0, seq_req}, 0);
    bus_rd(2'd3, rv); chk(rv == 32'h5A5, "R6 second result", rv, 32'h5A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_request();
    t_ignored();
    t_stray_pending();
    t_ack_abort();
    t_done();
    t_irq();
    t_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule